// File: doc/BRIEF.md
# Interlocked Strobe Read Link

This block joins a read-only requester and a memory responder over a bus that has no shared timing reference. Each side runs on its own clock. A read is carried by two strobes, a request strobe from the requester and an acknowledge strobe from the responder, in a four-phase interlocked sequence. Neither side relies on the other's clock or on a fixed latency. Each side crosses the other's strobe through its own synchronizer chain before acting on it.

Bus skew is handled by a hold-off on each side. The requester first drives the address and command. It raises its strobe only after a programmable number of its own clock cycles, so the address and command have settled at the far end. The responder fetches the word from its local memory and drives it onto the data lines. It then waits its own programmable count before raising the acknowledge. The requester treats the acknowledge as the only sign that the data is valid. It captures the word and drops its strobe. The responder then clears its data and drops the acknowledge. Only after seeing the acknowledge low does the requester remove the address and command.

A local user starts a read with a one-cycle pulse while the link is ready, and gets the word back with a one-cycle valid pulse. On the responder side, the block presents a read strobe and an address to a local memory that answers within the same cycle.

Top module: `hsk_read_link`

## Requirements
- R1: On an accepted start, the requester drives the address and the command at the next requester clock edge, with the request strobe still low. The command encodings are 2'b10 for a memory read, 2'b11 for an IO read and 2'b00 for idle.
- R2: The request strobe rises exactly M_DESKEW requester cycles after the address and command appear. Address and command stay unchanged while the strobe is high.
- R3: After the synchronized request strobe is seen, the responder issues a one-cycle memory read strobe. During that cycle, the memory address and the IO select (bit 0 of the command) match the bus, and the request strobe is high.
- R4: The acknowledge strobe rises exactly S_DESKEW responder cycles after the read word appears on the data lines. The data lines stay unchanged while the acknowledge is high.
- R5: The requester takes the data only after the synchronized acknowledge. The returned word equals the memory word for the requested address and space. The response valid is a single-cycle pulse.
- R6: After capturing the word, the requester drops the request strobe. The strobe falls only while the acknowledge is high.
- R7: When the responder sees the request strobe low, it drops the acknowledge and clears the data lines to zero at the same edge.
- R8: The requester returns the address and command to zero only after the acknowledge is low. The command is never idle while the request strobe is high.
- R9: Ready is high only when the requester is idle and the synchronized acknowledge is low. A start pulse while not ready is ignored: the bus address does not change and no extra response appears.
- R10: After reset, both strobes, the command, the address, the data lines and the response valid are zero, and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester clock |
| rst_m_n | input | 1 | Requester reset, active low |
| req_start | input | 1 | Start pulse for a read |
| req_addr | input | AW | Read address |
| req_io | input | 1 | 1 selects IO space, 0 memory space |
| req_ready | output | 1 | A start is accepted this cycle |
| rsp_valid | output | 1 | One-cycle pulse with the returned word |
| rsp_data | output | DW | Returned word |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low |
| mem_rd | output | 1 | One-cycle read strobe to the local memory |
| mem_addr | output | AW | Local memory address |
| mem_io | output | 1 | Local memory space select |
| mem_rdata | input | DW | Local memory word, valid in the read-strobe cycle |
| bus_addr | output | AW | Bus address lines, driven by the requester |
| bus_cmd | output | 2 | Bus command lines, driven by the requester |
| bus_msyn | output | 1 | Request strobe |
| bus_data | output | DW | Bus data lines, driven by the responder |
| bus_ssyn | output | 1 | Acknowledge strobe |

## Verification
The bench counts cycles from the address appearing to the request strobe. It does the same from the data appearing to the acknowledge. A design that shortened or stretched either hold-off, for example one with an off-by-one counter, would give a wrong count. The bench watches the ordering at teardown. If the address were withdrawn before the acknowledge fell, or the data were left on the lines after the acknowledge dropped, a check would report it. A start pulse is injected in the middle of a transaction to expose a requester that accepts work while busy. Random reads over both spaces, including the lowest and highest addresses, compare each returned word with a memory model. This catches data latched before the acknowledge or taken from the wrong space.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
   localparam logic [1:0] CMD_IDLE = 2'b00;
   localparam logic [1:0] CMD_MEM  = 2'b10;
   localparam logic [1:0] CMD_IO   = 2'b11;

   typedef enum logic [2:0] {
      M_IDLE, M_SETUP, M_WAIT_SSYN, M_RELEASE, M_WAIT_SSYN_LOW
   } mst_state_t;

   typedef enum logic [2:0] {
      S_IDLE, S_ACCESS, S_DESKEW, S_ASSERT, S_WAIT_MSYN_LOW
   } slv_state_t;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hsk_master.sv
module hsk_master
   import hsk_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int DESKEW      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] addr,
   input  logic          io,
   output logic          ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic [AW-1:0] bus_addr,
   output logic [1:0]    bus_cmd,
   output logic          bus_msyn,
   input  logic [DW-1:0] bus_data,
   input  logic          bus_ssyn
);
   localparam int CW = (DESKEW > 1) ? $clog2(DESKEW) : 1;

   mst_state_t    state;
   logic [CW-1:0] cnt;
   logic          ssyn_s;

   hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ssyn), .q(ssyn_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= M_IDLE;
         cnt       <= '0;
         bus_addr  <= '0;
         bus_cmd   <= CMD_IDLE;
         bus_msyn  <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            M_IDLE: begin
               if (start && !ssyn_s) begin
                  bus_addr <= addr;
                  bus_cmd  <= io ? CMD_IO : CMD_MEM;
                  cnt      <= '0;
                  state    <= M_SETUP;
               end
            end
            M_SETUP: begin
               if (cnt == CW'(DESKEW - 1)) begin
                  bus_msyn <= 1'b1;
                  state    <= M_WAIT_SSYN;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            M_WAIT_SSYN: begin
               if (ssyn_s) begin
                  rsp_data <= bus_data;
                  state    <= M_RELEASE;
               end
            end
            M_RELEASE: begin
               bus_msyn  <= 1'b0;
               rsp_valid <= 1'b1;
               state     <= M_WAIT_SSYN_LOW;
            end
            M_WAIT_SSYN_LOW: begin
               if (!ssyn_s) begin
                  bus_addr <= '0;
                  bus_cmd  <= CMD_IDLE;
                  state    <= M_IDLE;
               end
            end
            default: state <= M_IDLE;
         endcase
      end
   end

   assign ready = (state == M_IDLE) && !ssyn_s;
endmodule

// File: rtl/hsk_slave.sv
module hsk_slave
   import hsk_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int DESKEW      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [1:0]    bus_cmd,
   input  logic          bus_msyn,
   output logic [DW-1:0] bus_data,
   output logic          bus_ssyn,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic          mem_io,
   input  logic [DW-1:0] mem_rdata
);
   localparam int CW = (DESKEW > 1) ? $clog2(DESKEW) : 1;

   slv_state_t    state;
   logic [CW-1:0] cnt;
   logic          msyn_s;

   hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_msyn), .q(msyn_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cnt      <= '0;
         bus_data <= '0;
         bus_ssyn <= 1'b0;
         mem_rd   <= 1'b0;
         mem_addr <= '0;
         mem_io   <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (msyn_s && bus_cmd[1]) begin
                  mem_addr <= bus_addr;
                  mem_io   <= bus_cmd[0];
                  mem_rd   <= 1'b1;
                  state    <= S_ACCESS;
               end
            end
            S_ACCESS: begin
               bus_data <= mem_rdata;
               mem_rd   <= 1'b0;
               cnt      <= '0;
               state    <= S_DESKEW;
            end
            S_DESKEW: begin
               if (cnt == CW'(DESKEW - 1)) begin
                  bus_ssyn <= 1'b1;
                  state    <= S_ASSERT;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            S_ASSERT: state <= S_WAIT_MSYN_LOW;
            S_WAIT_MSYN_LOW: begin
               if (!msyn_s) begin
                  bus_ssyn <= 1'b0;
                  bus_data <= '0;
                  state    <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hsk_read_link.sv
module hsk_read_link #(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int M_DESKEW    = 2,
   parameter int S_DESKEW    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_m,
   input  logic          rst_m_n,
   input  logic          req_start,
   input  logic [AW-1:0] req_addr,
   input  logic          req_io,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   input  logic          clk_s,
   input  logic          rst_s_n,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic          mem_io,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] bus_addr,
   output logic [1:0]    bus_cmd,
   output logic          bus_msyn,
   output logic [DW-1:0] bus_data,
   output logic          bus_ssyn
);
   generate
      if (M_DESKEW < 1 || S_DESKEW < 1) begin : g_bad_deskew
         $error("hsk_read_link: deskew counts must be at least 1");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("hsk_read_link: widths must be positive");
      end
   endgenerate

   hsk_master #(
      .AW(AW), .DW(DW), .DESKEW(M_DESKEW), .SYNC_STAGES(SYNC_STAGES)
   ) u_mst (
      .clk(clk_m), .rst_n(rst_m_n),
      .start(req_start), .addr(req_addr), .io(req_io), .ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_msyn(bus_msyn),
      .bus_data(bus_data), .bus_ssyn(bus_ssyn)
   );

   hsk_slave #(
      .AW(AW), .DW(DW), .DESKEW(S_DESKEW), .SYNC_STAGES(SYNC_STAGES)
   ) u_slv (
      .clk(clk_s), .rst_n(rst_s_n),
      .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_msyn(bus_msyn),
      .bus_data(bus_data), .bus_ssyn(bus_ssyn),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_io(mem_io),
      .mem_rdata(mem_rdata)
   );
endmodule

// File: rtl/hsk_read_link_chk.sv
module hsk_read_link_chk #(
   parameter int AW       = 8,
   parameter int DW       = 16,
   parameter int M_DESKEW = 2,
   parameter int S_DESKEW = 3
) (
   input logic          clk_m,
   input logic          rst_m_n,
   input logic          clk_s,
   input logic          rst_s_n,
   input logic [AW-1:0] bus_addr,
   input logic [1:0]    bus_cmd,
   input logic          bus_msyn,
   input logic [DW-1:0] bus_data,
   input logic          bus_ssyn,
   input logic          rsp_valid
);
   localparam int MW = $clog2(M_DESKEW + 1);
   localparam int SW = $clog2(S_DESKEW + 1);

   logic          rst_any;
   logic [MW-1:0] m_stab;
   logic [AW+1:0] m_prev;
   logic [SW-1:0] s_stab;
   logic [DW-1:0] s_prev;

   assign rst_any = !rst_m_n || !rst_s_n;

   // cycles the address/command has held a non-idle value, saturating
   always_ff @(posedge clk_m or negedge rst_m_n) begin
      if (!rst_m_n) begin
         m_stab <= '0;
         m_prev <= '0;
      end else begin
         m_prev <= {bus_cmd, bus_addr};
         if (bus_cmd == 2'b00 || {bus_cmd, bus_addr} != m_prev) m_stab <= '0;
         else if (m_stab != MW'(M_DESKEW)) m_stab <= m_stab + MW'(1);
      end
   end

   // cycles the data lines have held their value, saturating
   always_ff @(posedge clk_s or negedge rst_s_n) begin
      if (!rst_s_n) begin
         s_stab <= '0;
         s_prev <= '0;
      end else begin
         s_prev <= bus_data;
         if (bus_data != s_prev) s_stab <= '0;
         else if (s_stab != SW'(S_DESKEW)) s_stab <= s_stab + SW'(1);
      end
   end

   assert_msyn_deskew_R2: assert property (@(posedge clk_m) disable iff (rst_any)
      $rose(bus_msyn) |-> (m_stab >= MW'(M_DESKEW - 1)));

   assert_addr_stable_R2: assert property (@(posedge clk_m) disable iff (rst_any)
      (bus_msyn && $past(bus_msyn)) |-> ($stable(bus_addr) && $stable(bus_cmd)));

   assert_ssyn_after_msyn_R3: assert property (@(posedge clk_s) disable iff (rst_any)
      $rose(bus_ssyn) |-> bus_msyn);

   assert_ssyn_deskew_R4: assert property (@(posedge clk_s) disable iff (rst_any)
      $rose(bus_ssyn) |-> (s_stab >= SW'(S_DESKEW - 1)));

   assert_data_stable_R4: assert property (@(posedge clk_s) disable iff (rst_any)
      (bus_ssyn && $past(bus_ssyn)) |-> $stable(bus_data));

   assert_rsp_pulse_R5: assert property (@(posedge clk_m) disable iff (rst_any)
      rsp_valid |=> !rsp_valid);

   assert_msyn_fall_R6: assert property (@(posedge clk_m) disable iff (rst_any)
      $fell(bus_msyn) |-> bus_ssyn);

   assert_cmd_hold_R8: assert property (@(posedge clk_m) disable iff (rst_any)
      bus_msyn |-> (bus_cmd != 2'b00));
endmodule

bind hsk_read_link hsk_read_link_chk #(
   .AW(AW), .DW(DW), .M_DESKEW(M_DESKEW), .S_DESKEW(S_DESKEW)
) u_chk (
   .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
   .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_msyn(bus_msyn),
   .bus_data(bus_data), .bus_ssyn(bus_ssyn), .rsp_valid(rsp_valid)
);

// File: tb/hsk_read_link_test.sv
module hsk_read_link_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int MD = 2;
   localparam int SD = 3;

   logic          clk_m = 1'b0, clk_s = 1'b0;
   logic          rst_m_n = 1'b0, rst_s_n = 1'b0;
   logic          req_start = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_io = 1'b0;
   logic          req_ready, rsp_valid, mem_rd, mem_io, bus_msyn, bus_ssyn;
   logic [DW-1:0] rsp_data, mem_rdata, bus_data;
   logic [AW-1:0] mem_addr, bus_addr;
   logic [1:0]    bus_cmd;

   int  n_cmp = 0, n_err = 0, n_rsp = 0, n_txn = 0;
   bit  mon_on = 1'b0, done = 1'b0;

   always #10 clk_m = ~clk_m;                  // 50 MHz requester clock
   initial begin #3; forever #8 clk_s = ~clk_s; end

   hsk_read_link #(.AW(AW), .DW(DW), .M_DESKEW(MD), .S_DESKEW(SD)) uut (.*);

   function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a, logic io);
      return {a ^ 8'hA5, ~a} ^ (io ? 16'h0F0F : 16'h0000);
   endfunction

   assign mem_rdata = mem_word(mem_addr, mem_io);

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // requester-side ordering monitor
   logic [1:0] prev_cmd = 2'b00;
   logic       prev_msyn = 1'b0;
   always @(negedge clk_m) if (mon_on) begin
      if (prev_cmd != 2'b00 && bus_cmd == 2'b00)
         chk(!bus_ssyn && !bus_msyn, "R8", "cmd withdrawn with strobe high",
             {bus_ssyn, bus_msyn}, 0);
      if (prev_msyn && !bus_msyn)
         chk(bus_ssyn, "R6", "request strobe fell without acknowledge", bus_ssyn, 1);
      if (rsp_valid) n_rsp++;
      prev_cmd  = bus_cmd;
      prev_msyn = bus_msyn;
   end

   // responder-side monitor
   logic [DW-1:0] prev_data = '0;
   logic          prev_ssyn = 1'b0;
   bit            trk = 1'b0;
   int            dcnt = 0;
   always @(negedge clk_s) if (mon_on) begin
      if (trk) begin
         dcnt++;
         if (bus_ssyn) begin
            chk(dcnt == SD, "R4", "data-to-acknowledge cycles", dcnt, SD);
            trk = 1'b0;
         end
      end else if (prev_data == '0 && bus_data != '0) begin
         chk(!bus_ssyn, "R4", "acknowledge with fresh data", bus_ssyn, 0);
         trk = 1'b1; dcnt = 0;
      end
      if (mem_rd)
         chk(mem_addr == bus_addr && mem_io == bus_cmd[0] && bus_msyn, "R3",
             "memory read address/space", {mem_io, mem_addr}, {bus_cmd[0], bus_addr});
      if (prev_ssyn && !bus_ssyn)
         chk(bus_data == '0 && !bus_msyn, "R7", "teardown data/strobe",
             {bus_msyn, bus_data}, 0);
      prev_data = bus_data;
      prev_ssyn = bus_ssyn;
   end

   task automatic do_read(logic [AW-1:0] a, logic io, bit poke);
      int k;
      while (!req_ready) @(negedge clk_m);
      req_start = 1'b1; req_addr = a; req_io = io;
      @(negedge clk_m);
      req_start = 1'b0;
      n_txn++;
      chk(bus_cmd == {1'b1, io} && bus_addr == a && !bus_msyn, "R1",
          "address/command first", {bus_msyn, bus_cmd, bus_addr}, {1'b0, 1'b1, io, a});
      k = 0;
      while (!bus_msyn && k < 50) begin @(negedge clk_m); k++; end
      chk(k == MD, "R2", "address-to-strobe cycles", k, MD);
      if (poke) begin
         req_start = 1'b1; req_addr = ~a; req_io = ~io;
         @(negedge clk_m);
         req_start = 1'b0;
         chk(bus_addr == a && !req_ready, "R9", "start while busy ignored",
             {req_ready, bus_addr}, {1'b0, a});
      end
      k = 0;
      while (!rsp_valid && k < 200) begin @(negedge clk_m); k++; end
      chk(rsp_valid && rsp_data == mem_word(a, io), "R5", "returned word",
          rsp_data, mem_word(a, io));
      @(negedge clk_m);
      chk(!rsp_valid && !bus_msyn, "R6", "strobe dropped, single pulse",
          {rsp_valid, bus_msyn}, 0);
      k = 0;
      while (!req_ready && k < 200) begin @(negedge clk_m); k++; end
      chk(bus_cmd == 2'b00 && bus_addr == '0 && !bus_ssyn, "R8", "idle bus after read",
          {bus_ssyn, bus_cmd, bus_addr}, 0);
   endtask

   initial begin
      void'($urandom(32'd20071018));
      repeat (4) @(negedge clk_m);
      rst_m_n = 1'b1; rst_s_n = 1'b1;
      @(negedge clk_m);
      mon_on = 1'b1;
      chk(req_ready && !bus_msyn && !bus_ssyn && bus_cmd == 0 && bus_addr == 0
          && bus_data == 0 && !rsp_valid, "R10", "reset state",
          {req_ready, bus_msyn, bus_ssyn, rsp_valid}, 4'b1000);
      // directed corners
      do_read(8'h00, 1'b0, 1'b0);
      do_read(8'hFF, 1'b1, 1'b0);
      do_read(8'h3C, 1'b1, 1'b1);
      do_read(8'hFF, 1'b0, 1'b1);
      // random traffic
      for (int i = 0; i < 40; i++) begin
         repeat ($urandom_range(0, 3)) @(negedge clk_m);
         do_read(AW'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0));
      end
      repeat (20) @(negedge clk_m);
      chk(n_rsp == n_txn, "R9", "response count", n_rsp, n_txn);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_m);
      if (!done) begin
         n_cmp++; n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end
endmodule